// File: doc/BRIEF.md
# Core Cluster Boot-Address and Power-Request Registers

This block is a small register bank on a 32-bit peripheral bus that serves a cluster of processor cores. For each core it holds a 64-bit boot address, split into a low and a high 32-bit word. The two words are joined and driven out on a wide output port, so the core picks up its start address when it leaves reset.

A single power-request register holds one bit per core. Software sets a bit to ask for that core to be powered down. Each request bit is driven out, one cycle after the write, as a power-status line. The request bit also qualifies the core's wait-for-interrupt indication. Each core's raw wait-for-interrupt input passes through a two-flop synchronizer. The gated output is high only while the core is idle and its power-down request is set, which tells an external power controller that the core can be switched off safely.

Only full-word writes are taken. Unmapped or misaligned offsets read as zero, ignore writes and never signal a bus error.

Top module: `core_boot_pwr_ctrl`

## Requirements
- R1: After reset, every low boot-address word reads 0xFFFF0000 and every high word reads 0. The power-request register reads 0. `wfi_out` and `pwr_status` are all low. `pready` is 1 and `pslverr` is 0.
- R2: Core n has its low boot-address word at byte offset 0x40+8n and its high word at 0x44+8n. Both words read back what was last written. Core n's 64-bit boot address sits at `rst_vec[64n+63:64n]` and equals {high word, low word}.
- R3: A write takes effect on the rising edge where `psel`, `penable` and `pwrite` are all high. `rst_vec` shows the new value right after that edge, and the other cores' vectors do not change.
- R4: The power-request register is at offset 0x90. Bit i is core i's power-down request. Reads return the request bits in [3:0] and zero in [31:4]. Writes to bits [31:4] are ignored.
- R5: `pwr_status[i]` equals request bit i and updates one clock after the write edge. It changes only when a write changes that bit.
- R6: `wfi_out[i]` is request bit i ANDed with `wfi_in[i]` after two synchronizer flops. It follows a change on `wfi_in` on the third rising edge and a change of the request bit on the first rising edge after the write.
- R7: A write whose `pstrb` is not 4'b1111 changes no register.
- R8: Reads of an unmapped offset, or an offset that is not a multiple of 4, return 0. Writes to such offsets change nothing. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; only 4'b1111 writes |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always 0 |
| wfi_in | input | 4 | Raw per-core wait-for-interrupt |
| wfi_out | output | 4 | Gated per-core wait-for-interrupt |
| pwr_status | output | 4 | Per-core power-down request status |
| rst_vec | output | 256 | Per-core 64-bit boot address, core n at [64n+63:64n] |

## Verification
Some rules are checked by assertions on every cycle:
- A gated wait-for-interrupt line is never high while its power-status line is low.
- `pwr_status` moves only when the stored request differs from it.
- `rst_vec` moves only after a bus write.
- Partial-strobe and unmapped writes leave every register unchanged.
- Upper read bits of the power-request register are zero.

Some facts only the bench's scenarios can show:
- The offset of each word.
- The reset values.
- The exact three-edge synchronizer latency and the one-edge request latency.
- That all 256 request/idle combinations give the correct AND.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
    localparam int WORD_W    = 32;
    localparam int STRB_W    = WORD_W / 8;
    localparam int VEC_W     = 2 * WORD_W;
    localparam int RVEC_BASE = 'h40;
    localparam int RVEC_STEP = 8;
    localparam int PWR_OFS   = 'h90;
    localparam logic [WORD_W-1:0] LO_RESET = 32'hFFFF_0000;
    localparam logic [WORD_W-1:0] HI_RESET = 32'h0000_0000;
endpackage

// File: rtl/cbp_sync.sv
module cbp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cbp_regfile.sv
module cbp_regfile
    import cbp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [WORD_W-1:0]           pwdata,
    input  logic [STRB_W-1:0]           pstrb,
    output logic [WORD_W-1:0]           prdata,
    output logic [NUM_CORES-1:0]        pd_req,
    output logic [NUM_CORES*VEC_W-1:0]  rst_vec
);
    typedef struct packed {
        logic [NUM_CORES-1:0][WORD_W-1:0] lo;
        logic [NUM_CORES-1:0][WORD_W-1:0] hi;
        logic [NUM_CORES-1:0]             pd;
    } regs_t;

    regs_t st_d, st_q;

    logic                 aligned, wr_fire, pd_hit, any_hit, wr_access;
    logic [NUM_CORES-1:0] lo_hit, hi_hit;

    // address decode
    always_comb begin
        aligned = (paddr[1:0] == 2'b00);
        for (int n = 0; n < NUM_CORES; n++) begin
            lo_hit[n] = aligned && (paddr == ADDR_W'(RVEC_BASE + RVEC_STEP * n));
            hi_hit[n] = aligned && (paddr == ADDR_W'(RVEC_BASE + RVEC_STEP * n + 4));
        end
        pd_hit    = aligned && (paddr == ADDR_W'(PWR_OFS));
        any_hit   = (|lo_hit) || (|hi_hit) || pd_hit;
        wr_access = psel && penable && pwrite;
        wr_fire   = wr_access && (pstrb == '1);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_fire) begin
            for (int n = 0; n < NUM_CORES; n++) begin
                if (lo_hit[n]) st_d.lo[n] = pwdata;
                if (hi_hit[n]) st_d.hi[n] = pwdata;
            end
            if (pd_hit) st_d.pd = pwdata[NUM_CORES-1:0];
        end
    end

    // read mux
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            for (int n = 0; n < NUM_CORES; n++) begin
                if (lo_hit[n]) prdata = st_q.lo[n];
                if (hi_hit[n]) prdata = st_q.hi[n];
            end
            if (pd_hit) prdata = WORD_W'(st_q.pd);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lo <= {NUM_CORES{LO_RESET}};
            st_q.hi <= {NUM_CORES{HI_RESET}};
            st_q.pd <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_vec
        assign rst_vec[n*VEC_W +: VEC_W] = {st_q.hi[n], st_q.lo[n]};
    end

    assign pd_req = st_q.pd;

    // R7
    strb_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && (pstrb != '1)) |=> $stable(st_q));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_access && !any_hit) |=> $stable(st_q));

    // R4
    pwr_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && pd_hit) |-> (prdata[WORD_W-1:NUM_CORES] == '0));

    // R3
    rvec_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rst_vec) |-> $past(wr_access));
endmodule

// File: rtl/cbp_wfi_gate.sv
module cbp_wfi_gate #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] pd_req,
    input  logic [NUM_CORES-1:0] wfi_sync,
    output logic [NUM_CORES-1:0] wfi_out,
    output logic [NUM_CORES-1:0] pwr_status
);
    typedef struct packed {
        logic [NUM_CORES-1:0] wfi;
        logic [NUM_CORES-1:0] pwr;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.wfi = pd_req & wfi_sync;
        g_d.pwr = pd_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign wfi_out    = g_q.wfi;
    assign pwr_status = g_q.pwr;

    // R6
    wfi_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.wfi & ~g_q.pwr) == '0);

    // R5
    pwr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(g_q.pwr) |-> ($past(pd_req) != $past(g_q.pwr)));
endmodule

// File: rtl/core_boot_pwr_ctrl.sv
module core_boot_pwr_ctrl
    import cbp_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [WORD_W-1:0]          pwdata,
    input  logic [STRB_W-1:0]          pstrb,
    output logic [WORD_W-1:0]          prdata,
    output logic                       pready,
    output logic                       pslverr,
    input  logic [NUM_CORES-1:0]       wfi_in,
    output logic [NUM_CORES-1:0]       wfi_out,
    output logic [NUM_CORES-1:0]       pwr_status,
    output logic [NUM_CORES*VEC_W-1:0] rst_vec
);
    logic [NUM_CORES-1:0] pd_req, wfi_sync;

    cbp_sync #(.WIDTH(NUM_CORES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wfi_in),
        .dout (wfi_sync)
    );

    cbp_regfile #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .psel   (psel),
        .penable(penable),
        .pwrite (pwrite),
        .paddr  (paddr),
        .pwdata (pwdata),
        .pstrb  (pstrb),
        .prdata (prdata),
        .pd_req (pd_req),
        .rst_vec(rst_vec)
    );

    cbp_wfi_gate #(.NUM_CORES(NUM_CORES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .wfi_sync  (wfi_sync),
        .wfi_out   (wfi_out),
        .pwr_status(pwr_status)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: tb/core_boot_pwr_ctrl_test.sv
module core_boot_pwr_ctrl_test;
    localparam int PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]   paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [3:0]   pstrb = '0;
    logic [31:0]  prdata;
    logic         pready, pslverr;
    logic [3:0]   wfi_in = '0;
    logic [3:0]   wfi_out, pwr_status;
    logic [255:0] rst_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] lo_m [4];
    logic [31:0] hi_m [4];
    logic [3:0]  pd_m;

    core_boot_pwr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .wfi_in(wfi_in), .wfi_out(wfi_out),
        .pwr_status(pwr_status), .rst_vec(rst_vec)
    );

    always #(PER/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; pstrb = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic check_all_regs(input string req);
        logic [31:0] d;
        for (int n = 0; n < 4; n++) begin
            bus_rd(8'(8'h40 + 8*n), d);     check(req, 64'(d), 64'(lo_m[n]));
            bus_rd(8'(8'h44 + 8*n), d);     check(req, 64'(d), 64'(hi_m[n]));
            check(req, rst_vec[n*64 +: 64], {hi_m[n], lo_m[n]});
        end
        bus_rd(8'h90, d); check(req, 64'(d), 64'(pd_m));
    endtask

    function automatic bit mapped(input int a);
        return (a >= 'h40 && a < 'h60) || a == 'h90;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  old_w;
        for (int n = 0; n < 4; n++) begin lo_m[n] = 32'hFFFF_0000; hi_m[n] = 0; end
        pd_m = 0;
        wfi_in = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1 reset state
        check("R1 wfi_out", 64'(wfi_out), 0);
        check("R1 pwr_status", 64'(pwr_status), 0);
        check("R1 pready", 64'(pready), 1);
        check("R1 pslverr", 64'(pslverr), 0);
        check_all_regs("R1");
        wfi_in = 0;

        // R2 R3 boot vector sweep
        for (int n = 0; n < 4; n++) begin
            logic [31:0] lv, hv;
            lv = 32'h1234_5000 * (n + 1) ^ 32'h0000_0ACC;
            hv = 32'hA5A5_0000 + 32'(n * 17);
            bus_wr(8'(8'h40 + 8*n), lv, 4'hF);
            lo_m[n] = lv;
            for (int m = 0; m < 4; m++)
                check("R3 lo update", rst_vec[m*64 +: 64], {hi_m[m], lo_m[m]});
            bus_wr(8'(8'h44 + 8*n), hv, 4'hF);
            hi_m[n] = hv;
            for (int m = 0; m < 4; m++)
                check("R3 hi update", rst_vec[m*64 +: 64], {hi_m[m], lo_m[m]});
        end
        check_all_regs("R2");

        // R7 partial strobes ignored
        bus_wr(8'h40, 32'hDEAD_BEEF, 4'b0111);
        bus_wr(8'h4C, 32'hDEAD_BEEF, 4'b1110);
        bus_wr(8'h90, 32'h0000_000F, 4'b0001);
        @(posedge clk); #1;
        check("R7 pwr_status", 64'(pwr_status), 0);
        check_all_regs("R7");

        // R4 R5 upper bits ignored, status latency
        bus_wr(8'h90, 32'hFFFF_FFF5, 4'hF);
        pd_m = 4'h5;
        check("R5 before edge", 64'(pwr_status), 0);
        @(posedge clk); #1;
        check("R5 after edge", 64'(pwr_status), 5);
        bus_rd(8'h90, d);
        check("R4 readback", 64'(d), 64'h5);
        bus_wr(8'h90, 32'h5, 4'hF);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check("R5 same value", 64'(pwr_status), 5);
        end

        // R6 request change latency with idle cores
        @(negedge clk); wfi_in = 4'hF;
        repeat (3) @(posedge clk); #1;
        check("R6 settle", 64'(wfi_out), 5);
        bus_wr(8'h90, 32'hA, 4'hF);
        pd_m = 4'hA;
        check("R6 pd before edge", 64'(wfi_out), 5);
        @(posedge clk); #1;
        check("R6 pd after edge", 64'(wfi_out), 4'hA);

        // R6 R5 sweep of all request/idle combinations
        old_w = 4'hF;
        for (int p = 0; p < 16; p++) begin
            bus_wr(8'h90, 32'(p), 4'hF);
            pd_m = 4'(p);
            for (int w = 0; w < 16; w++) begin
                @(negedge clk); wfi_in = 4'(w);
                @(posedge clk); @(posedge clk); #1;
                check("R6 sync latency", 64'(wfi_out), 64'(pd_m & old_w));
                @(posedge clk); #1;
                check("R6 gated", 64'(wfi_out), 64'(pd_m & 4'(w)));
                check("R5 follows", 64'(pwr_status), 64'(pd_m));
                old_w = 4'(w);
            end
        end

        // R8 unmapped and misaligned
        for (int a = 0; a < 256; a += 4) begin
            if (!mapped(a)) begin
                bus_rd(8'(a), d);
                check("R8 unmapped read", 64'(d), 0);
                check("R8 pslverr", 64'(pslverr), 0);
            end
        end
        bus_rd(8'h41, d); check("R8 misaligned read", 64'(d), 0);
        bus_rd(8'h92, d); check("R8 misaligned read", 64'(d), 0);
        bus_wr(8'h00, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'h94, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'h42, 32'hFFFF_FFFF, 4'hF);
        bus_wr(8'h91, 32'hFFFF_FFFF, 4'hF);
        @(posedge clk); #1;
        check("R8 pwr_status", 64'(pwr_status), 64'(pd_m));
        check_all_regs("R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule